// File: doc/BRIEF.md
# Oversampling Asynchronous Frame Receiver

This block takes in serial frames from a line that idles high. A frame has 10 bits (start, eight data bits, stop) or 11 bits (start, eight data bits, a ninth bit, stop). The line is looked at once per pulse of a tick input that runs at sixteen times the bit rate. A bit rate generator outside the block supplies that tick. When the line first reads low while the receiver is hunting, a four-bit phase counter restarts, so later bit windows line up with the incoming bit edges. Within each window the line is sampled at phases 7, 8 and 9, and the bit takes the value that at least two of the three samples agree on. A start bit that votes high is treated as noise and dropped.

A shift register is filled with ones when the start edge is found. Voted bits enter on the right. When the start bit reaches the left end of the active width, the next voted bit is the last one. On that bit the block delivers the byte and the ninth bit to its output registers and raises a completion flag, but only if the flag is clear and, when the address filter input is set, only if the ninth bit is 1. The ninth bit is the stop bit in the 10-bit format.

The controller has three states. ST_ARM waits until the line reads high on a tick while reception is enabled, then goes to ST_HUNT. ST_HUNT waits for a low tick, which is the start edge, then goes to ST_BITS. ST_BITS counts phases and shifts voted bits. It goes back to ST_ARM on a false start or after the last bit. Dropping the enable sends any state back to ST_ARM.

Top module: `osr_frame_rx`

## Requirements
- R1: After reset, rx_done, rx_data and rx_bit9 are all 0.
- R2: In the 10-bit format (fmt11=0), a frame is received as start 0, eight data bits LSB first, then stop 1. The start edge is the first tick on which the line reads low in ST_HUNT, and that tick is phase 0. On the final bit the byte goes to rx_data, the stop bit goes to rx_bit9, and rx_done is set.
- R3: Each bit is the majority of the line samples at phases 7, 8 and 9 of its 16-tick window, so a single wrong sample at phase 8 does not change the bit.
- R4: A start bit that votes 1 loads nothing. The receiver goes back to waiting for the line to be high and then for a new edge, and it receives a following frame correctly.
- R5: In the 11-bit format (fmt11=1), the bit after the eight data bits goes to rx_bit9, and the stop bit after it is not stored.
- R6: A frame whose final bit arrives while rx_done is 1 is discarded. rx_data, rx_bit9 and rx_done do not change.
- R7: When addr_filt is 1, a frame with a ninth bit of 0 is discarded, and a frame with a ninth bit of 1 is loaded.
- R8: flag_clr clears rx_done. The load decision uses the flag value from before any clear in that same cycle. So a clear that coincides with the final bit of a frame still discards that frame and leaves rx_done at 0.
- R9: While rx_en is 0 the line is ignored. After rx_en is set, the line must be seen high on a tick before a low tick counts as a start edge, so a line held low never starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| fmt11 | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| rx_en | input | 1 | Receive enable |
| addr_filt | input | 1 | Load only frames whose ninth bit is 1 |
| flag_clr | input | 1 | Clears rx_done |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Stop bit (10-bit) or ninth bit (11-bit) |
| rx_done | output | 1 | Receive-complete flag |

## Verification
The final shift of a frame, together with its load decision, can land in the same clock cycle as a flag clear. The bench sets this up by leaving rx_done high after one frame. It then sends another frame and raises flag_clr on the exact tick at phase 9 of that frame's stop bit. After that tick the bench expects rx_done at 0 and the earlier byte and ninth bit still in place. This shows that the gate read the flag before the clear took effect.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_HUNT = 2'd1,
        ST_BITS = 2'd2
    } rx_state_e;

    localparam int PHASE_W = 4;
    localparam int BYTE_W  = 8;
endpackage

// File: rtl/osr_rx_vote.sv
module osr_rx_vote #(
    parameter int CNT_W = 4,
    parameter int MID   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic active,
    input  logic line,
    output logic decide_o,
    output logic bit_o
);
    localparam logic [CNT_W-1:0] PH_A = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] PH_B = CNT_W'(MID);
    localparam logic [CNT_W-1:0] PH_C = CNT_W'(MID + 1);

    logic [CNT_W-1:0] phase;
    logic             samp_a, samp_b;
    logic             step;

    assign step = active && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else begin
            if (restart)
                phase <= CNT_W'(1);
            else if (step)
                phase <= phase + CNT_W'(1);
            if (step && phase == PH_A)
                samp_a <= line;
            if (step && phase == PH_B)
                samp_b <= line;
        end
    end

    assign decide_o = step && (phase == PH_C);
    assign bit_o    = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);

    AST_DECIDE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |-> $past(active)); // R3
endmodule

// File: rtl/osr_rx_shift.sv
module osr_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preload,
    input  logic              shift_en,
    input  logic              din,
    input  logic              fmt11,
    output logic              last_o,
    output logic              fresh_o,
    output logic [DATA_W-1:0] data_o,
    output logic              nine_o
);
    localparam int SR_W = DATA_W + 2;

    logic [SR_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '1;
        else if (preload)
            sr <= '1;
        else if (shift_en)
            sr <= {sr[SR_W-2:0], din};
    end

    assign last_o  = fmt11 ? ~sr[DATA_W+1] : ~sr[DATA_W];
    assign fresh_o = &sr;
    assign nine_o  = fmt11 ? sr[0] : din;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_unpack
        assign data_o[gi] = fmt11 ? sr[DATA_W-gi] : sr[DATA_W-1-gi];
    end
endmodule

// File: rtl/osr_frame_rx.sv
module osr_frame_rx
    import osr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic              fmt11,
    input  logic              rx_en,
    input  logic              addr_filt,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done
);
    rx_state_e   state, state_nx;
    logic        edge_det, decide, voted;
    logic        last, fresh, nine, load, false_start;
    logic [BYTE_W-1:0] frame_byte;

    assign edge_det    = rx_en && (state == ST_HUNT) && tick16 && !rx_line;
    assign false_start = decide && fresh && voted;
    assign load        = rx_en && decide && !fresh && last && !rx_done
                         && (!addr_filt || nine);

    osr_rx_vote #(.CNT_W(PHASE_W), .MID(8)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .restart  (edge_det),
        .active   (rx_en && state == ST_BITS),
        .line     (rx_line),
        .decide_o (decide),
        .bit_o    (voted)
    );

    osr_rx_shift #(.DATA_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .preload  (edge_det),
        .shift_en (decide && !false_start),
        .din      (voted),
        .fmt11    (fmt11),
        .last_o   (last),
        .fresh_o  (fresh),
        .data_o   (frame_byte),
        .nine_o   (nine)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ARM;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!rx_en) begin
            state_nx = ST_ARM;
        end else begin
            unique case (state)
                ST_ARM:  if (tick16 && rx_line) state_nx = ST_HUNT;
                ST_HUNT: if (edge_det) state_nx = ST_BITS;
                ST_BITS: if (false_start || (decide && last && !fresh))
                             state_nx = ST_ARM;
                default: state_nx = ST_ARM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (load) begin
                rx_data <= frame_byte;
                rx_bit9 <= nine;
                rx_done <= 1'b1;
            end else if (flag_clr) begin
                rx_done <= 1'b0;
            end
        end
    end

    AST_DONE_FROM_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(state == ST_BITS && tick16)); // R2
    AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> $stable(rx_data) && $stable(rx_bit9)); // R6
    AST_FILTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> (!$past(addr_filt) || rx_bit9)); // R7
    AST_CLEAR_WINS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && rx_done) |=> !rx_done); // R8
    AST_DISABLED_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_ARM); // R9
endmodule

// File: tb/osr_frame_rx_tb.sv
module osr_frame_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic       fmt11 = 1'b0;
    logic       rx_en = 1'b0;
    logic       addr_filt = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       n;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    osr_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .fmt11(fmt11), .rx_en(rx_en), .addr_filt(addr_filt),
        .flag_clr(flag_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_done(rx_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic one_tick(input logic v, input logic clr);
        @(negedge clk);
        rx_line  = v;
        tick16   = 1'b1;
        flag_clr = clr;
        @(negedge clk);
        tick16   = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) one_tick(1'b1, 1'b0);
    endtask

    // Driver: sends a frame; pushes the expected result when a load is due.
    task automatic send_frame(input logic [7:0] d, input logic nine, input bit f11,
                              input int glitch_bit, input bit clr_last,
                              input bit expect_load, input string tag);
        logic b [11];
        int   nb;
        fmt11 = f11;
        nb = f11 ? 11 : 10;
        b[0] = 1'b0;
        for (int i = 0; i < 8; i++) b[i+1] = d[i];
        b[9] = f11 ? nine : 1'b1;
        b[10] = 1'b1;
        if (expect_load) sb.push_back('{d, f11 ? nine : 1'b1, tag});
        idle(3);
        for (int k = 0; k < nb; k++)
            for (int s = 0; s < 16; s++)
                one_tick((k == glitch_bit && s == 8) ? ~b[k] : b[k],
                         clr_last && k == nb - 1 && s == 9);
        idle(3);
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // Monitor: pops an expected item at each new completion.
    logic done_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_done && !done_q) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6/R7 unexpected load", {rx_bit9, rx_data}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rx_data == e.d, e.tag, rx_data, e.d);
                check(rx_bit9 == e.n, e.tag, rx_bit9, e.n);
            end
        end
        done_q <= rx_done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_done == 1'b0 && rx_data == 8'h00 && rx_bit9 == 1'b0, "R1 reset",
              {rx_done, rx_bit9, rx_data}, 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        idle(4);

        // R2 basic 10-bit frame
        send_frame(8'hA5, 1'b0, 1'b0, -1, 1'b0, 1'b1, "R2 10-bit frame");
        check(rx_done == 1'b1, "R2 done set", rx_done, 1);
        clear_flag();
        check(rx_done == 1'b0, "R8 clear", rx_done, 0);

        // R3 glitch on data bit at phase 8
        send_frame(8'h3C, 1'b0, 1'b0, 3, 1'b0, 1'b1, "R3 glitch voted out");
        clear_flag();

        // R4 false start then a real frame
        one_tick(1'b0, 1'b0);
        for (int s = 1; s < 16; s++) one_tick(1'b1, 1'b0);
        idle(200);
        check(rx_done == 1'b0, "R4 false start loads nothing", rx_done, 0);
        send_frame(8'h81, 1'b0, 1'b0, -1, 1'b0, 1'b1, "R4 frame after false start");
        clear_flag();

        // R5 11-bit ninth bit 0 then 1
        send_frame(8'h5A, 1'b0, 1'b1, -1, 1'b0, 1'b1, "R5 ninth bit 0");
        clear_flag();
        send_frame(8'hC3, 1'b1, 1'b1, 4, 1'b0, 1'b1, "R5 ninth bit 1");

        // R6 flag still set: frame lost
        send_frame(8'h55, 1'b0, 1'b1, -1, 1'b0, 1'b0, "R6");
        check(rx_done == 1'b1 && rx_data == 8'hC3 && rx_bit9 == 1'b1, "R6 frame discarded",
              {rx_done, rx_bit9, rx_data}, {2'b11, 8'hC3});

        // R8 clear coincides with final bit: still discarded
        send_frame(8'h0F, 1'b1, 1'b1, -1, 1'b1, 1'b0, "R8");
        check(rx_done == 1'b0 && rx_data == 8'hC3, "R8 clear on final bit",
              {rx_done, rx_data}, {1'b0, 8'hC3});

        // R7 address filter
        addr_filt = 1'b1;
        send_frame(8'h77, 1'b0, 1'b1, -1, 1'b0, 1'b0, "R7");
        check(rx_done == 1'b0 && rx_data == 8'hC3, "R7 ninth 0 filtered",
              {rx_done, rx_data}, {1'b0, 8'hC3});
        send_frame(8'h12, 1'b1, 1'b1, -1, 1'b0, 1'b1, "R7 ninth 1 passes");
        clear_flag();
        addr_filt = 1'b0;

        // R9 disabled: line ignored
        rx_en = 1'b0;
        send_frame(8'h99, 1'b0, 1'b0, -1, 1'b0, 1'b0, "R9");
        check(rx_done == 1'b0 && rx_data == 8'h12, "R9 disabled ignores line",
              {rx_done, rx_data}, {1'b0, 8'h12});
        // R9 enabled with line held low: no frame
        for (int i = 0; i < 4; i++) one_tick(1'b0, 1'b0);
        rx_en = 1'b1;
        for (int i = 0; i < 200; i++) one_tick(1'b0, 1'b0);
        idle(20);
        check(rx_done == 1'b0 && rx_data == 8'h12, "R9 held-low line no trigger",
              {rx_done, rx_data}, {1'b0, 8'h12});
        send_frame(8'hE7, 1'b0, 1'b0, -1, 1'b0, 1'b1, "R9 frame after re-arm");

        idle(4);
        check(sb.size() == 0, "R2 all expected frames seen", sb.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule